// File: doc/BRIEF.md
# Posted-Write Register Synchronizer

This block sits between a register bus clocked by `bclk` and the register file of a timer clocked by `fclk`. Ten registers are carried across the clock boundary. For each of them the bus side keeps a shadow copy and a pending flag. A write lands in the shadow, and its pending flag rises. A toggle travels to the functional side, which copies the shadow into its own register and raises a one-cycle update strobe. The acknowledge toggle then returns and clears the flag. Software reads the flags as one status word, so it can avoid a register whose previous value is still in flight.

Two more registers live only in the bus domain and are written at once, without tracking. One is an interface control word and the other is a wake-up enable word. Bit 2 of the interface control word selects the write mode. When it is 1 (posted), the bus sees a write completed at once. When it is 0 (stalling), the bus is held until the value has reached the functional side and the acknowledge has returned. In both modes, a write aimed at a register whose flag is still set is held off, so no earlier value is overwritten before it crosses.

Top module: `wpend_bridge`

## Requirements
- R1: After reset the pending status word reads 0, interface control reads 0x4 (posted mode on), wake-up enable reads 0, and every functional register is 0.
- R2: Bus addresses 0 to 9 are the synchronized registers. Bit i of the pending status word (read address 12) is the flag of register i.
- R3: In posted mode, a write to a synchronized register whose flag is clear is accepted in the cycle it is presented (`bw_ready` high), and its flag reads 1 from the next bus cycle.
- R4: Every accepted write to register i yields exactly one `f_upd[i]` pulse, in write order. The pulse comes with the written value on slice i of `f_regs`, and the slice does not change without a pulse. Once the value has crossed, the flag returns to 0.
- R5: A write to a register whose flag is set is held (`bw_ready` low) until the flag clears. Both the earlier and the later value then reach the functional side.
- R6: In stalling mode (interface control bit 2 = 0), `bw_ready` for a synchronized register is withheld until the handshake completes. In the accepting cycle the flag is already 0 and the functional register already holds the new value.
- R7: Writes to address 10 (interface control) and address 11 (wake-up enable) are accepted in the same cycle and take effect the next cycle. They leave every pending flag at 0 and produce no functional update.
- R8: Writes to address 12 and above are accepted and change no state.
- R9: Reading a synchronized register's address returns the last value accepted for it on the bus side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain asynchronous reset, active low |
| bw_valid | input | 1 | Write request, held until `bw_ready` |
| bw_addr | input | AW | Write address |
| bw_data | input | DW | Write data |
| bw_ready | output | 1 | Write accepted in this cycle |
| br_addr | input | AW | Read address |
| br_data | output | DW | Read data, combinational from `br_addr` |
| wake_en | output | DW | Wake-up enable register (bus domain, untracked) |
| fclk | input | 1 | Functional clock |
| frst_n | input | 1 | Functional-domain asynchronous reset, active low |
| f_regs | output | NREG*DW | Functional-side registers, register i at slice i |
| f_upd | output | NREG | One-cycle update strobe per functional register |

## Verification
The assertions assume that the bus master holds `bw_valid`, `bw_addr` and `bw_data` steady until `bw_ready`. They also assume that the mode bit is not flipped while a stalling write is outstanding. The bench drives every write through one task that keeps the request steady until acceptance. It changes the mode only after all flags have drained. The two clocks are unrelated (periods of 10 and 14), so the synchronizer latency varies from one transfer to the next. The scoreboard therefore checks the order and values of updates, not their exact cycles.

// File: rtl/wpend_bridge.sv
`timescale 1ns/1ps
module wpend_bridge #(
  parameter int DW = 32,
  parameter int NREG = 10,
  parameter int AW = 4,
  parameter int POSTED_BIT = 2
)(
  input  logic                 bclk,
  input  logic                 brst_n,
  input  logic                 bw_valid,
  input  logic [AW-1:0]        bw_addr,
  input  logic [DW-1:0]        bw_data,
  output logic                 bw_ready,
  input  logic [AW-1:0]        br_addr,
  output logic [DW-1:0]        br_data,
  output logic [DW-1:0]        wake_en,
  input  logic                 fclk,
  input  logic                 frst_n,
  output logic [NREG*DW-1:0]   f_regs,
  output logic [NREG-1:0]      f_upd
);
  localparam logic [AW-1:0] A_IFC  = AW'(NREG);
  localparam logic [AW-1:0] A_WAKE = AW'(NREG + 1);
  localparam logic [AW-1:0] A_PEND = AW'(NREG + 2);
  localparam logic [DW-1:0] IFC_RST = DW'(1) << POSTED_BIT;

  logic [DW-1:0]   shadow_v [NREG];
  logic [NREG-1:0] hit, pend;
  logic [DW-1:0]   ifc;
  logic            posted, sel_sync, tgt_busy, launch, launched;

  assign posted   = ifc[POSTED_BIT];
  assign sel_sync = bw_addr < A_IFC;
  assign tgt_busy = |(hit & pend);
  assign launch   = bw_valid && sel_sync && !tgt_busy && (posted || !launched);
  assign bw_ready = !sel_sync || (!tgt_busy && (posted || launched));

  always_ff @(posedge bclk or negedge brst_n)
    if (!brst_n)                 launched <= 1'b0;
    else if (posted)             launched <= 1'b0;
    else if (launch)             launched <= 1'b1;
    else if (bw_valid && bw_ready) launched <= 1'b0;

  always_ff @(posedge bclk or negedge brst_n)
    if (!brst_n) begin
      ifc     <= IFC_RST;
      wake_en <= '0;
    end else if (bw_valid) begin
      if (bw_addr == A_IFC)  ifc     <= bw_data;
      if (bw_addr == A_WAKE) wake_en <= bw_data;
    end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] sh, fr;
    logic          rq, am, as, rm, rs, at, up;

    assign hit[i]      = bw_addr == AW'(i);
    assign pend[i]     = rq ^ as;
    assign shadow_v[i] = sh;
    assign f_regs[i*DW +: DW] = fr;
    assign f_upd[i]    = up;

    always_ff @(posedge bclk or negedge brst_n)
      if (!brst_n) begin
        sh <= '0;
        rq <= 1'b0;
        am <= 1'b0;
        as <= 1'b0;
      end else begin
        am <= at;
        as <= am;
        if (launch && hit[i]) begin
          sh <= bw_data;
          rq <= ~rq;
        end
      end

    always_ff @(posedge fclk or negedge frst_n)
      if (!frst_n) begin
        rm <= 1'b0;
        rs <= 1'b0;
        at <= 1'b0;
        up <= 1'b0;
        fr <= '0;
      end else begin
        rm <= rq;
        rs <= rm;
        up <= 1'b0;
        if (rs != at) begin
          at <= rs;
          fr <= sh;
          up <= 1'b1;
        end
      end
  end

  always_comb begin
    br_data = '0;
    if (br_addr < A_IFC) begin
      for (int i = 0; i < NREG; i++)
        if (br_addr == AW'(i)) br_data = shadow_v[i];
    end else if (br_addr == A_IFC)  br_data = ifc;
    else if (br_addr == A_WAKE)     br_data = wake_en;
    else if (br_addr == A_PEND)     br_data = DW'(pend);
  end
endmodule

module wpend_bridge_chk #(
  parameter int DW = 32,
  parameter int NREG = 10,
  parameter int AW = 4
)(
  input logic               bclk,
  input logic               brst_n,
  input logic               fclk,
  input logic               frst_n,
  input logic               bw_valid,
  input logic [AW-1:0]      bw_addr,
  input logic               bw_ready,
  input logic [NREG-1:0]    pend,
  input logic               posted,
  input logic [NREG*DW-1:0] f_regs,
  input logic [NREG-1:0]    f_upd
);
  a_r1_reset_idle: assert property (@(posedge bclk) !brst_n |=> (pend == '0 && posted));

  a_r7_direct_ready: assert property (@(posedge bclk) disable iff (!brst_n)
    (bw_valid && bw_addr >= AW'(NREG)) |-> bw_ready);

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    a_r5_hold_busy: assert property (@(posedge bclk) disable iff (!brst_n)
      (bw_valid && bw_addr == AW'(i) && pend[i]) |-> !bw_ready);

    a_r3_pend_sets: assert property (@(posedge bclk) disable iff (!brst_n)
      (bw_valid && bw_ready && posted && bw_addr == AW'(i)) |=> pend[i]);

    a_r6_stall_done: assert property (@(posedge bclk) disable iff (!brst_n)
      (bw_valid && bw_ready && !posted && bw_addr == AW'(i)) |-> !pend[i]);

    a_r4_change_strobed: assert property (@(posedge fclk) disable iff (!frst_n)
      !$stable(f_regs[i*DW +: DW]) |-> f_upd[i]);
  end
endmodule

bind wpend_bridge wpend_bridge_chk #(.DW(DW), .NREG(NREG), .AW(AW)) u_chk (
  .bclk(bclk), .brst_n(brst_n), .fclk(fclk), .frst_n(frst_n),
  .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_ready(bw_ready),
  .pend(pend), .posted(posted), .f_regs(f_regs), .f_upd(f_upd)
);

// File: tb/wpend_bridge_test.sv
`timescale 1ns/1ps
module wpend_bridge_test;
  localparam int DW = 32;
  localparam int NREG = 10;
  localparam int AW = 4;
  localparam int BCLK_P = 10;
  localparam int FCLK_P = 14;
  localparam logic [AW-1:0] A_IFC  = 4'd10;
  localparam logic [AW-1:0] A_WAKE = 4'd11;
  localparam logic [AW-1:0] A_PEND = 4'd12;

  logic bclk = 1'b0, fclk = 1'b0;
  logic brst_n, frst_n, bw_valid, bw_ready;
  logic [AW-1:0] bw_addr, br_addr;
  logic [DW-1:0] bw_data, br_data, wake_en;
  logic [NREG*DW-1:0] f_regs;
  logic [NREG-1:0] f_upd;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int q_idx[$];
  logic [DW-1:0] q_val[$];
  int e_i;
  logic [DW-1:0] e_v;

  always #(BCLK_P/2) bclk = ~bclk;
  always #(FCLK_P/2) fclk = ~fclk;

  wpend_bridge #(.DW(DW), .NREG(NREG), .AW(AW)) uut (
    .bclk(bclk), .brst_n(brst_n), .bw_valid(bw_valid), .bw_addr(bw_addr),
    .bw_data(bw_data), .bw_ready(bw_ready), .br_addr(br_addr), .br_data(br_data),
    .wake_en(wake_en), .fclk(fclk), .frst_n(frst_n), .f_regs(f_regs), .f_upd(f_upd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output int waits);
    @(negedge bclk);
    bw_valid = 1'b1; bw_addr = a; bw_data = d; waits = 0;
    if (a < AW'(NREG)) begin
      q_idx.push_back(int'(a));
      q_val.push_back(d);
    end
    #1;
    while (!bw_ready && waits < 300) begin
      @(negedge bclk); #1;
      waits++;
    end
    @(negedge bclk);
    bw_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    br_addr = a;
    #1;
    d = br_data;
  endtask

  task automatic drain();
    logic [DW-1:0] p;
    int n = 0;
    rd(A_PEND, p);
    while (p != 0 && n < 300) begin
      @(negedge bclk);
      rd(A_PEND, p);
      n++;
    end
    chk(p == 0, "R4", "pending flags drain", p, 0);
  endtask

  function automatic logic [DW-1:0] fslice(input int i);
    return f_regs[i*DW +: DW];
  endfunction

  // scoreboard monitor: each functional update must match the oldest queued write
  always @(negedge fclk) begin
    if (frst_n) begin
      for (int i = 0; i < NREG; i++) begin
        if (f_upd[i]) begin
          if (q_idx.size() == 0) chk(1'b0, "R4", "unexpected update", DW'(i), '1);
          else begin
            e_i = q_idx.pop_front();
            e_v = q_val.pop_front();
            chk(e_i == i, "R4", "update order", DW'(i), DW'(e_i));
            chk(fslice(i) == e_v, "R5", "updated value", fslice(i), e_v);
          end
        end
      end
    end
  end

  initial begin
    #(BCLK_P * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int w;
    brst_n = 1'b0; frst_n = 1'b0; bw_valid = 1'b0;
    bw_addr = '0; bw_data = '0; br_addr = '0;
    repeat (4) @(negedge bclk);
    brst_n = 1'b1; frst_n = 1'b1;
    @(negedge bclk);

    // R1 reset state
    rd(A_PEND, v); chk(v == 0, "R1", "pending after reset", v, 0);
    rd(A_IFC, v);  chk(v == 32'h4, "R1", "interface control after reset", v, 32'h4);
    chk(wake_en == 0, "R1", "wake enable after reset", wake_en, 0);
    chk(f_regs == '0, "R1", "functional regs after reset", fslice(0), 0);

    // R3 / R2 posted write to register 2
    wr(4'd2, 32'hA5A5_0002, w);
    chk(w == 0, "R3", "posted accept wait", DW'(w), 0);
    rd(A_PEND, v); chk(v == 32'h4, "R2", "pending bit position", v, 32'h4);
    rd(4'd2, v); chk(v == 32'hA5A5_0002, "R9", "shadow readback", v, 32'hA5A5_0002);
    drain();
    chk(fslice(2) == 32'hA5A5_0002, "R4", "functional reg 2", fslice(2), 32'hA5A5_0002);

    // R5 back-to-back writes to the same register
    wr(4'd3, 32'h1111_0003, w);
    wr(4'd3, 32'h2222_0003, w);
    chk(w > 0, "R5", "second write held", DW'(w), 1);
    drain();
    chk(fslice(3) == 32'h2222_0003, "R5", "final value reg 3", fslice(3), 32'h2222_0003);

    // R2 burst over all registers
    for (int i = 0; i < NREG; i++) wr(AW'(i), 32'h100 + i, w);
    rd(A_PEND, v); chk(v[9] == 1'b1, "R2", "pending bit 9 after burst", v, 32'h200);
    drain();
    for (int i = 0; i < NREG; i++)
      chk(fslice(i) == 32'h100 + i, "R4", "burst value", fslice(i), 32'h100 + i);

    // R7 direct register
    wr(A_WAKE, 32'h0000_1234, w);
    chk(w == 0, "R7", "direct accept wait", DW'(w), 0);
    chk(wake_en == 32'h1234, "R7", "wake enable value", wake_en, 32'h1234);
    rd(A_PEND, v); chk(v == 0, "R7", "no pending from direct write", v, 0);

    // R8 writes to status and unmapped addresses are ignored
    wr(A_PEND, 32'hFFFF_FFFF, w);
    chk(w == 0, "R8", "status write accepted", DW'(w), 0);
    wr(4'd15, 32'hFFFF_FFFF, w);
    rd(A_PEND, v); chk(v == 0, "R8", "pending unchanged", v, 0);
    rd(A_IFC, v); chk(v == 32'h4, "R8", "interface control unchanged", v, 32'h4);
    chk(wake_en == 32'h1234, "R8", "wake enable unchanged", wake_en, 32'h1234);

    // R6 stalling mode
    wr(A_IFC, 32'h0, w);
    rd(A_IFC, v); chk(v == 0, "R7", "interface control written", v, 0);
    wr(4'd5, 32'h0000_BEEF, w);
    chk(w >= 3, "R6", "stall cycles", DW'(w), 3);
    rd(A_PEND, v); chk(v == 0, "R6", "pending clear at completion", v, 0);
    chk(fslice(5) == 32'hBEEF, "R6", "functional reg at completion", fslice(5), 32'hBEEF);
    wr(4'd7, 32'h0000_7777, w);
    chk(fslice(7) == 32'h7777, "R6", "second stalled write", fslice(7), 32'h7777);

    // back to posted
    wr(A_IFC, 32'h4, w);
    wr(4'd6, 32'h0000_6666, w);
    chk(w == 0, "R3", "posted after mode restore", DW'(w), 0);
    drain();
    repeat (10) @(negedge fclk);
    chk(q_idx.size() == 0, "R4", "all writes delivered", DW'(q_idx.size()), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule